// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Sequencer

This block is the control engine of one DMA channel. Software starts the channel by writing an instruction number. The channel then reads an eight-word transfer descriptor from a local instruction RAM. This read takes two clocks per word and needs no system bus. The channel then waits for a device or software request. It asks the arbiter for the bus and steps a separate cycle engine through the words of the block. The cycle engine reports each finished word with `cyc_done`, or a failed word with `cyc_err`. As words complete, the sequencer counts down the remaining words and moves two area address counters.

When a block is finished, the channel does one of two things. It can follow the descriptor's link field to the next descriptor. Or it can raise its end-of-transfer flag and wait until software clears that flag. Errors park the channel in an error state. It leaves that state only when every error flag has been cleared. While a loaded channel is waiting, software can also force the end flag or an error flag, and a fixed set of precedence rules applies.

Descriptor word layout: word 0 is the link word, word 1 the block length, word 2 the area-1 start address, and word 4 the area-2 start address. The other words are read but not used. The fields of the link word are bit 15 enable, bits 14:12 transfer kind, bits 11:10 area-1 stepping, bits 9:8 area-2 stepping, bit 7 force-stop, bit 6 link enable and bits 5:0 next descriptor. The transfer kinds are 000 one word, 001 word pair, 010 burst, 011 unused, and 1xx area-to-area. The state codes are 0 idle, 1 loading/waiting, 2 request pending, 3 transferring, 4 burst parked, 5 end wait and 6 error.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is idle (state 0). `bus_req`, `eot_flag`, `req_pend` and all of `err_flags` are low.
- R2: A `mode_wr` with `mode_act`=1 while idle, with `mode_inst` below 60, enters state 1. The channel then reads exactly eight RAM words starting at address 8×instruction, one read strobe every second clock, over 16 clocks. `bus_req` stays low during these reads.
- R3: If `ram_perr` returns with any descriptor word, the channel goes to state 6 with `err_flags` bit 0 set.
- R4: A loaded channel stays in state 1 until `dreq` is high or the pending flag (status write bit 1) is set. It then goes to state 2 with `bus_req` high and clears the pending flag. A grant then moves it to state 3.
- R5: In state 2, a descriptor whose enable bit is 0, or whose transfer kind is 011, returns the channel to idle and moves no words.
- R6: One-word and area-to-area kinds return to state 2 after every word. The word-pair kind moves two words per grant. The burst kind moves words back to back while granted. If the grant is low when a word completes, the burst goes to state 4 with `bus_req` held, and resumes on re-grant.
- R7: Each completed word decrements `words_left`, which is loaded from the block length. Area 1 steps on every word. Area 2 steps only in area-to-area kinds. The stepping codes are 00 hold, 01 +1, 10 −1 and 11 hold. Each area starts at its start address.
- R8: At the end of a block, the channel loads the next descriptor and keeps going when the link-enable bit is 1, the force-stop bit is 0 and the next value is below 60 (values 60–63 stop the chain). Otherwise it sets `eot_flag` and enters state 5. Clearing the flag there returns it to idle.
- R9: A word-pair descriptor with an odd block length sends the channel to state 6 with `err_flags` bit 1 set.
- R10: `cyc_err` during a transfer sends the channel to state 6 with `err_flags` bit 2 set.
- R11: Status writes in state 1 work as follows (bit 0 end, bits 5:2 error flags). Error bits and the end bit written together change nothing. Error bits alone go to state 6. The end bit alone goes to state 5. In state 6, writing the end bit clears the errors and goes to state 5. In state 5, writing error bits clears the end flag and goes to state 6.
- R12: A `mode_wr` with `mode_act`=0 in state 1 or state 2 returns the channel to idle.
- R13: State 6 is left only by a status write that leaves every error flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_act | input | 1 | Mode write: 1 start, 0 stop |
| mode_inst | input | 6 | Mode write: first descriptor number |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 6 | Status write: bit0 end, bit1 pending, bits5:2 error flags |
| dreq | input | 1 | Device request, active high |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| cyc_done | input | 1 | Cycle engine finished one word |
| cyc_err | input | 1 | Cycle engine reports a failed word |
| ram_rdata | input | 16 | Instruction RAM read data (one clock latency) |
| ram_perr | input | 1 | Parity error flag returned with `ram_rdata` |
| ram_rd | output | 1 | Instruction RAM read strobe |
| ram_addr | output | 9 | Instruction RAM word address |
| bus_req | output | 1 | Bus request to the arbiter |
| xfer_go | output | 1 | Cycle engine may run a word |
| xfer_mode | output | 3 | Transfer kind of the current descriptor |
| area1_addr | output | 16 | Current area-1 address |
| area2_addr | output | 16 | Current area-2 address |
| words_left | output | 16 | Remaining words in the block |
| chan_state | output | 3 | Channel state code |
| eot_flag | output | 1 | End-of-transfer flag |
| err_flags | output | 4 | Error flags: parity, length, bus, software |
| req_pend | output | 1 | Software request pending flag |

## Verification
Each of the five transfer kinds is run with a different mix of stepping codes: hold, +1, −1 and the second hold code. The final area addresses therefore show which counter moved and in which direction. Counting how often the channel passes through the request-pending state tells one-word, pair and burst sequencing apart, even when they move the same number of words. Directed runs cover grant removal in a burst, chains that continue, that stop at a reserved pointer and that stop through the force-stop bit, and each path into and out of the error and end states, including the flag-write precedence rules.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHAIN = 3'd1,
    S_PREQ  = 3'd2,
    S_XFER  = 3'd3,
    S_PARK  = 3'd4,
    S_EOTW  = 3'd5,
    S_ERR   = 3'd6
  } st_t;

  localparam logic [2:0] K_SINGLE = 3'b000;
  localparam logic [2:0] K_PAIR   = 3'b001;
  localparam logic [2:0] K_BURST  = 3'b010;
  localparam logic [2:0] K_NONE   = 3'b011;

  typedef struct packed {
    logic       act;
    logic [2:0] kind;
    logic [1:0] a1m;
    logic [1:0] a2m;
    logic       fstop;
    logic       link;
    logic [5:0] nxt;
  } link_t;
endpackage

// File: rtl/dcs_fetch.sv
module dcs_fetch #(
  parameter int DW     = 16,
  parameter int PTRW   = 6,
  parameter int DWORDS = 8,
  localparam int WSEL  = $clog2(DWORDS),
  localparam int CNTW  = WSEL + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [PTRW-1:0]      inst,
  output logic                 ram_rd,
  output logic [PTRW+WSEL-1:0] ram_addr,
  input  logic [DW-1:0]        ram_rdata,
  input  logic                 ram_perr,
  output logic                 done,
  output logic                 perr,
  output dcs_pkg::link_t       lk,
  output logic [DW-1:0]        blen,
  output logic [DW-1:0]        base1,
  output logic [DW-1:0]        base2
);
  logic [CNTW-1:0] cnt;
  logic            busy;
  logic [WSEL-1:0] widx;

  assign widx     = cnt[CNTW-1:1];
  assign ram_rd   = busy & ~cnt[0];
  assign ram_addr = {inst, widx};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      done  <= 1'b0;
      perr  <= 1'b0;
      lk    <= '0;
      blen  <= '0;
      base1 <= '0;
      base2 <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        perr <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt[0]) begin
          perr <= perr | ram_perr;
          case (widx)
            WSEL'(0): lk    <= dcs_pkg::link_t'(ram_rdata[15:0]);
            WSEL'(1): blen  <= ram_rdata;
            WSEL'(2): base1 <= ram_rdata;
            WSEL'(4): base2 <= ram_rdata;
            default: ;
          endcase
        end
        if (cnt == '1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dcs_area.sv
module dcs_area #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] base,
  input  logic [1:0]   amode,
  input  logic         step,
  output logic [W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= base;
    end else if (step) begin
      case (amode)
        2'b01:   addr <= addr + 1'b1;
        2'b10:   addr <= addr - 1'b1;
        default: addr <= addr;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int DW     = 16,
  parameter int PTRW   = 6,
  parameter int NDESC  = 60,
  parameter int DWORDS = 8,
  localparam int WSEL  = $clog2(DWORDS),
  localparam int RAW   = PTRW + WSEL,
  localparam int NERR  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_wr,
  input  logic            mode_act,
  input  logic [PTRW-1:0] mode_inst,
  input  logic            stat_wr,
  input  logic [5:0]      stat_wdata,
  input  logic            dreq,
  input  logic            bus_gnt,
  input  logic            cyc_done,
  input  logic            cyc_err,
  input  logic [DW-1:0]   ram_rdata,
  input  logic            ram_perr,
  output logic            ram_rd,
  output logic [RAW-1:0]  ram_addr,
  output logic            bus_req,
  output logic            xfer_go,
  output logic [2:0]      xfer_mode,
  output logic [DW-1:0]   area1_addr,
  output logic [DW-1:0]   area2_addr,
  output logic [DW-1:0]   words_left,
  output logic [2:0]      chan_state,
  output logic            eot_flag,
  output logic [NERR-1:0] err_flags,
  output logic            req_pend
);
  import dcs_pkg::*;

  st_t            st;
  logic [PTRW-1:0] inst;
  logic           loaded, second;
  link_t          lk;
  logic [DW-1:0]  blen, b1, b2;
  logic           fdone, fperr;
  logic [DW-1:0]  remain_nx;
  logic           last, chain_go, word_ok, fstart, mode_start, mode_stop;
  logic [NERR-1:0] wr_err;
  logic           wr_eot;

  assign wr_err     = stat_wdata[5:2];
  assign wr_eot     = stat_wdata[0];
  assign remain_nx  = words_left - 1'b1;
  assign last       = (remain_nx == '0);
  assign chain_go   = lk.link && !lk.fstop && (lk.nxt < PTRW'(NDESC));
  assign word_ok    = (st == S_XFER) && cyc_done && !cyc_err;
  assign mode_start = mode_wr && mode_act && (st == S_IDLE) && (mode_inst < PTRW'(NDESC));
  assign mode_stop  = mode_wr && !mode_act && ((st == S_CHAIN) || (st == S_PREQ));
  assign fstart     = mode_start || (word_ok && last && chain_go);

  dcs_fetch #(.DW(DW), .PTRW(PTRW), .DWORDS(DWORDS)) u_fetch (
    .clk(clk), .rst(rst), .start(fstart), .inst(inst),
    .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_perr(ram_perr),
    .done(fdone), .perr(fperr), .lk(lk), .blen(blen), .base1(b1), .base2(b2)
  );

  logic [DW-1:0] abase [2];
  logic [1:0]    amode [2];
  logic          astep [2];
  logic [DW-1:0] aout  [2];
  assign abase[0] = b1;
  assign abase[1] = b2;
  assign amode[0] = lk.a1m;
  assign amode[1] = lk.a2m;
  assign astep[0] = word_ok;
  assign astep[1] = word_ok && lk.kind[2];

  for (genvar g = 0; g < 2; g++) begin : g_area
    dcs_area #(.W(DW)) u_area (
      .clk(clk), .rst(rst), .load(fdone && (st == S_CHAIN)),
      .base(abase[g]), .amode(amode[g]), .step(astep[g]), .addr(aout[g])
    );
  end
  assign area1_addr = aout[0];
  assign area2_addr = aout[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      inst       <= '0;
      loaded     <= 1'b0;
      second     <= 1'b0;
      eot_flag   <= 1'b0;
      err_flags  <= '0;
      req_pend   <= 1'b0;
      words_left <= '0;
    end else begin
      if (stat_wr) req_pend <= stat_wdata[1];
      if (fdone && (st == S_CHAIN)) words_left <= blen;
      case (st)
        S_IDLE: if (mode_start) begin
          st     <= S_CHAIN;
          inst   <= mode_inst;
          loaded <= 1'b0;
        end
        S_CHAIN: begin
          if (mode_stop) begin
            st <= S_IDLE;
          end else if (stat_wr && ((wr_err != '0) || wr_eot)) begin
            if ((wr_err != '0) && !wr_eot) begin
              err_flags <= wr_err;
              eot_flag  <= 1'b0;
              st        <= S_ERR;
            end else if ((wr_err == '0) && wr_eot) begin
              eot_flag  <= 1'b1;
              err_flags <= '0;
              st        <= S_EOTW;
            end
          end else if (fdone && !loaded) begin
            if (fperr) begin
              err_flags[0] <= 1'b1;
              st           <= S_ERR;
            end else if ((lk.kind == K_PAIR) && blen[0]) begin
              err_flags[1] <= 1'b1;
              st           <= S_ERR;
            end else begin
              loaded <= 1'b1;
            end
          end else if (loaded && (dreq || req_pend)) begin
            st       <= S_PREQ;
            req_pend <= 1'b0;
            second   <= 1'b0;
          end
        end
        S_PREQ: begin
          if (mode_stop || !lk.act || (lk.kind == K_NONE)) st <= S_IDLE;
          else if (bus_gnt) st <= S_XFER;
        end
        S_XFER: begin
          if (cyc_err) begin
            err_flags[2] <= 1'b1;
            st           <= S_ERR;
          end else if (cyc_done) begin
            words_left <= remain_nx;
            if (last) begin
              if (chain_go) begin
                inst   <= lk.nxt;
                loaded <= 1'b0;
                st     <= S_CHAIN;
              end else begin
                eot_flag <= 1'b1;
                st       <= S_EOTW;
              end
            end else begin
              case (lk.kind)
                K_PAIR: begin
                  second <= ~second;
                  if (second) st <= S_PREQ;
                end
                K_BURST: if (!bus_gnt) st <= S_PARK;
                default: st <= S_PREQ;
              endcase
            end
          end
        end
        S_PARK: if (bus_gnt) st <= S_XFER;
        S_EOTW: if (stat_wr) begin
          if (wr_err != '0) begin
            err_flags <= wr_err;
            eot_flag  <= 1'b0;
            st        <= S_ERR;
          end else if (!wr_eot) begin
            eot_flag <= 1'b0;
            st       <= S_IDLE;
          end
        end
        S_ERR: if (stat_wr) begin
          if (wr_eot) begin
            eot_flag  <= 1'b1;
            err_flags <= '0;
            st        <= S_EOTW;
          end else begin
            err_flags <= wr_err;
            if (wr_err == '0) st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign chan_state = st;
  assign bus_req    = (st == S_PREQ) || (st == S_XFER) || (st == S_PARK);
  assign xfer_go    = (st == S_XFER);
  assign xfer_mode  = lk.kind;
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    chan_state,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          ram_rd,
  input logic          cyc_done,
  input logic          cyc_err,
  input logic          eot_flag,
  input logic [3:0]    err_flags,
  input logic [DW-1:0] words_left
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (chan_state == 3'd0) |-> !bus_req); // R1
  AST_FETCH_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
    ram_rd |-> !bus_req); // R2
  AST_FETCH_SPACING: assert property (@(posedge clk) disable iff (rst)
    ram_rd |=> !ram_rd); // R2
  AST_XFER_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    ((chan_state == 3'd2) && bus_gnt) |=> (chan_state == 3'd3) || (chan_state == 3'd0)); // R4
  AST_WORD_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    ((chan_state == 3'd3) && cyc_done && !cyc_err) |=> (words_left == $past(words_left) - DW'(1))); // R7
  AST_EOTW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (chan_state == 3'd5) |-> eot_flag); // R8
  AST_ERR_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (chan_state == 3'd6) |-> (err_flags != 4'd0)); // R13
endmodule

bind dma_chan_seq dcs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .chan_state(chan_state), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .ram_rd(ram_rd), .cyc_done(cyc_done), .cyc_err(cyc_err), .eot_flag(eot_flag),
  .err_flags(err_flags), .words_left(words_left)
);

// File: tb/sim_dma_chan_seq.sv
`timescale 1ns/1ps
module sim_dma_chan_seq;
  logic clk = 0, rst = 1;
  logic mode_wr = 0, mode_act = 0, stat_wr = 0, dreq = 0, bus_gnt = 0, cyc_done = 0, cyc_err = 0;
  logic [5:0] mode_inst = 0, stat_wdata = 0;
  logic [15:0] ram_rdata = 0;
  logic ram_perr = 0, ram_rd, bus_req, xfer_go, eot_flag, req_pend;
  logic [8:0] ram_addr;
  logic [2:0] xfer_mode, chan_state;
  logic [15:0] area1_addr, area2_addr, words_left;
  logic [3:0] err_flags;

  always #2.5 clk = ~clk;

  dma_chan_seq u0 (.*);

  logic [15:0] mem [512];
  int perr_addr = -1;
  int rd_cnt = 0;
  int first_rd = -1;
  always @(posedge clk) if (ram_rd) begin
    ram_rdata <= mem[ram_addr];
    ram_perr  <= (int'(ram_addr) == perr_addr);
    if (rd_cnt == 0) first_rd = int'(ram_addr);
    rd_cnt = rd_cnt + 1;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] lnk(input bit act, input logic [2:0] k, input logic [1:0] m1,
                                      input logic [1:0] m2, input bit fs, input bit ln, input logic [5:0] nx);
    return {act, k, m1, m2, fs, ln, nx};
  endfunction

  task automatic put_desc(input int n, input logic [15:0] w0, input logic [15:0] len,
                          input logic [15:0] b1, input logic [15:0] b2);
    for (int k = 0; k < 8; k++) mem[n*8+k] = 16'h0;
    mem[n*8+0] = w0; mem[n*8+1] = len; mem[n*8+2] = b1; mem[n*8+4] = b2;
  endtask

  int bus_seen;
  task automatic start(input int n);
    @(negedge clk); mode_wr = 1; mode_act = 1; mode_inst = 6'(n);
    @(negedge clk); mode_wr = 0;
    bus_seen = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (bus_req) bus_seen++; end
  endtask

  task automatic swr(input logic [5:0] v);
    @(negedge clk); stat_wr = 1; stat_wdata = v;
    @(negedge clk); stat_wr = 0;
  endtask

  int drop_at = -1;
  bit saw_park;
  task automatic serve(output int words, output int preqs);
    int drop_left = 0;
    words = 0; preqs = 0; saw_park = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (chan_state == 3'd4 && bus_req) saw_park = 1;
      if (chan_state == 3'd2) preqs++;
      if (xfer_go && words == drop_at) drop_left = 4;
      bus_gnt  = bus_req && (drop_left == 0);
      if (drop_left > 0) drop_left--;
      cyc_done = xfer_go;
      if (xfer_go) words++;
      if (!xfer_go && (chan_state == 3'd0 || chan_state == 3'd5 || chan_state == 3'd6)) break;
    end
    cyc_done = 0; bus_gnt = 0;
  endtask

  typedef struct packed {
    logic [2:0] kind; logic [1:0] m1; logic [1:0] m2;
    logic [15:0] len; logic [15:0] b1; logic [15:0] b2;
    logic [15:0] e1; logic [15:0] e2; logic [7:0] preq;
  } vec_t;
  localparam vec_t VT [5] = '{
    '{3'b000, 2'b01, 2'b00, 16'd3, 16'h0100, 16'h0000, 16'h0103, 16'h0000, 8'd3},
    '{3'b001, 2'b10, 2'b00, 16'd4, 16'h0200, 16'h0000, 16'h01FC, 16'h0000, 8'd2},
    '{3'b010, 2'b00, 2'b00, 16'd5, 16'h0300, 16'h0000, 16'h0300, 16'h0000, 8'd1},
    '{3'b100, 2'b01, 2'b10, 16'd3, 16'h0040, 16'h0080, 16'h0043, 16'h007D, 8'd3},
    '{3'b111, 2'b11, 2'b01, 16'd2, 16'h0010, 16'h0020, 16'h0010, 16'h0022, 8'd2}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w, p;
    for (int k = 0; k < 512; k++) mem[k] = 16'h0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 state", chan_state, 0); chk("R1 bus_req", bus_req, 0);
    chk("R1 eot", eot_flag, 0); chk("R1 errs", err_flags, 0); chk("R1 pend", req_pend, 0);

    // R2 descriptor fetch
    put_desc(7, lnk(1, 3'b000, 2'b01, 2'b00, 0, 0, 0), 16'd1, 16'h0500, 16'h0);
    rd_cnt = 0; first_rd = -1;
    start(7);
    chk("R2 reads", rd_cnt, 8); chk("R2 first addr", first_rd, 56);
    chk("R2 no bus", bus_seen, 0); chk("R2 state", chan_state, 1);
    // R4 waits, software pending request
    repeat (10) @(negedge clk);
    chk("R4 waits", chan_state, 1);
    swr(6'b000010);
    @(negedge clk);
    chk("R4 preq", chan_state, 2); chk("R4 bus_req", bus_req, 1); chk("R4 pend cleared", req_pend, 0);
    serve(w, p);
    chk("R4 words", w, 1); chk("R8 eotw", chan_state, 5); chk("R7 a1", area1_addr, 16'h0501);
    swr(6'b000000);
    chk("R8 idle", chan_state, 0);

    // table walk: R6 R7 R8
    for (int i = 0; i < 5; i++) begin
      put_desc(10+i, lnk(1, VT[i].kind, VT[i].m1, VT[i].m2, 0, 0, 0), VT[i].len, VT[i].b1, VT[i].b2);
      start(10+i);
      dreq = 1;
      serve(w, p);
      dreq = 0;
      chk("R6 words", w, int'(VT[i].len));
      chk("R6 preq visits", p, int'(VT[i].preq));
      chk("R7 area1", area1_addr, VT[i].e1);
      chk("R7 area2", area2_addr, VT[i].e2);
      chk("R7 left", words_left, 0);
      chk("R8 eot", eot_flag, 1);
      swr(6'b000000);
      chk("R8 cleared", chan_state, 0);
    end

    // R6 burst park
    put_desc(16, lnk(1, 3'b010, 2'b01, 2'b00, 0, 0, 0), 16'd6, 16'h0700, 16'h0);
    start(16); dreq = 1; drop_at = 2;
    serve(w, p);
    dreq = 0; drop_at = -1;
    chk("R6 park seen", saw_park, 1); chk("R6 park words", w, 6); chk("R7 park a1", area1_addr, 16'h0706);
    swr(6'b000000);

    // R8 chaining
    put_desc(20, lnk(1, 3'b010, 2'b01, 2'b00, 0, 1, 6'd21), 16'd2, 16'h0800, 16'h0);
    put_desc(21, lnk(1, 3'b010, 2'b10, 2'b00, 0, 0, 6'd0), 16'd3, 16'h0900, 16'h0);
    rd_cnt = 0;
    start(20); dreq = 1;
    serve(w, p); dreq = 0;
    chk("R8 chain words", w, 5); chk("R8 chain reads", rd_cnt, 16);
    chk("R8 chain a1", area1_addr, 16'h08FD); chk("R8 chain eotw", chan_state, 5);
    swr(6'b000000);
    // reserved pointer stops the chain
    put_desc(22, lnk(1, 3'b000, 2'b01, 2'b00, 0, 1, 6'h3C), 16'd2, 16'h0A00, 16'h0);
    rd_cnt = 0;
    start(22); dreq = 1;
    serve(w, p); dreq = 0;
    chk("R8 stop ptr words", w, 2); chk("R8 stop ptr reads", rd_cnt, 8); chk("R8 stop ptr eotw", chan_state, 5);
    swr(6'b000000);
    // force-stop bit overrides link
    put_desc(23, lnk(1, 3'b000, 2'b01, 2'b00, 1, 1, 6'd21), 16'd1, 16'h0B00, 16'h0);
    rd_cnt = 0;
    start(23); dreq = 1;
    serve(w, p); dreq = 0;
    chk("R8 fstop words", w, 1); chk("R8 fstop reads", rd_cnt, 8); chk("R8 fstop eotw", chan_state, 5);
    swr(6'b000000);

    // R5 deactivating descriptors
    put_desc(24, lnk(0, 3'b000, 2'b01, 2'b00, 0, 0, 0), 16'd2, 16'h0C00, 16'h0);
    start(24); dreq = 1;
    serve(w, p); dreq = 0;
    chk("R5 disabled idle", chan_state, 0); chk("R5 disabled words", w, 0);
    put_desc(25, lnk(1, 3'b011, 2'b01, 2'b00, 0, 0, 0), 16'd2, 16'h0C00, 16'h0);
    start(25); dreq = 1;
    serve(w, p); dreq = 0;
    chk("R5 kind011 idle", chan_state, 0); chk("R5 kind011 words", w, 0);

    // R12 software stop
    start(7);
    @(negedge clk); mode_wr = 1; mode_act = 0;
    @(negedge clk); mode_wr = 0;
    chk("R12 stop", chan_state, 0);

    // R9 odd pair length, R13 exit rule
    put_desc(26, lnk(1, 3'b001, 2'b01, 2'b00, 0, 0, 0), 16'd3, 16'h0D00, 16'h0);
    start(26);
    chk("R9 err state", chan_state, 6); chk("R9 ble", err_flags, 4'b0010);
    swr(6'b000100);
    chk("R13 stays", chan_state, 6); chk("R13 flags", err_flags, 4'b0001);
    swr(6'b000000);
    chk("R13 exit", chan_state, 0);

    // R3 parity error
    put_desc(27, lnk(1, 3'b000, 2'b01, 2'b00, 0, 0, 0), 16'd2, 16'h0E00, 16'h0);
    perr_addr = 27*8+3;
    start(27);
    perr_addr = -1;
    chk("R3 err state", chan_state, 6); chk("R3 ipe", err_flags, 4'b0001);
    swr(6'b000000);

    // R10 bus error
    put_desc(28, lnk(1, 3'b010, 2'b01, 2'b00, 0, 0, 0), 16'd4, 16'h0F00, 16'h0);
    start(28); dreq = 1;
    for (int k = 0; k < 20 && !xfer_go; k++) begin @(negedge clk); bus_gnt = bus_req; end
    @(negedge clk); cyc_err = 1;
    @(negedge clk); cyc_err = 0; bus_gnt = 0; dreq = 0;
    chk("R10 err state", chan_state, 6); chk("R10 bus flag", err_flags, 4'b0100);
    swr(6'b000000);

    // R11 software flag ordering
    start(7);
    swr(6'b100001);
    chk("R11 both no change", chan_state, 1); chk("R11 both flags", {eot_flag, err_flags}, 0);
    swr(6'b100000);
    chk("R11 err state", chan_state, 6); chk("R11 err flag", err_flags, 4'b1000);
    swr(6'b000001);
    chk("R11 eot clears err", err_flags, 0); chk("R11 eotw", chan_state, 5);
    swr(6'b010000);
    chk("R11 err clears eot", eot_flag, 0); chk("R11 err again", chan_state, 6);
    swr(6'b000000);
    chk("R13 final idle", chan_state, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule